// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block serves one active-low external interrupt pin. The raw pin is brought into the clock domain through a chain of flip-flops. A trigger stage then turns it into events, either on falling edges only or, in level mode, on falling edges and on a pin that stays low. Each event sets a pending latch. Software reads the latch through a single byte-wide control and status register and clears it by writing a one to a strobe bit. A mask bit gates the interrupt request towards the processor. It does not gate the latch itself.

The same register holds a bit that switches off the pin's internal pull-up. The block only drives this bit out as a control signal. The register bus is minimal: an address, a write enable, write data, and read data decoded combinationally. When the address does not select the register, read data is zero.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `irq_req` is 0 and `pullup_off` is 0.
- R2: Register bit layout: bit 6 pull-up off (read/write), bit 3 pending (read-only), bit 2 acknowledge (write-only, always reads 0), bit 1 mask (read/write), bit 0 trigger mode (read/write, 0 = falling edge, 1 = edge plus low level). Bits 7, 5 and 4 read 0, and writes to them are ignored.
- R3: With `pin_n` idle high, a pin driven low before a rising clock edge shows up as pending on the third rising edge and not earlier.
- R4: In level mode, an acknowledge written while the pin is still low leaves pending at 1. Once the pin has been high for two clock cycles, an acknowledge clears it.
- R5: In edge mode, a write with bit 2 set clears pending. A pin held low does not set it again.
- R6: When an acknowledge write and a new trigger event fall on the same clock edge, pending stays 1.
- R7: `irq_req` is 1 exactly when pending is 1 and mask is 0. Pending still sets while the mask is 1.
- R8: `pullup_off` follows register bit 6 from the clock edge of the write.
- R9: A write to any address other than `REG_ADDR` changes nothing, and a read of another address returns 0.
- R10: In edge mode, a rising edge on the pin does not set pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not selected |
| pin_n | input | 1 | Raw active-low interrupt pin |
| irq_req | output | 1 | Interrupt request to the processor |
| pullup_off | output | 1 | 1 switches the internal pull-up off |

## Verification
An acknowledge write and a freshly detected event can land on the same clock edge. In that case the latch must stay set. The bench provokes this by driving the pin low and raising the acknowledge write two clock edges later, so that the write meets the edge on which the event reaches the latch. It then checks that pending still reads 1, that it read 0 one cycle before, and that a later plain acknowledge clears it. Level mode runs into the same overlap every cycle the pin stays low, and that case is judged by pending surviving an acknowledge.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int DATA_W  = 8;
  localparam int B_PUOFF = 6;
  localparam int B_PEND  = 3;
  localparam int B_ACK   = 2;
  localparam int B_MASK  = 1;
  localparam int B_MODE  = 0;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  typedef struct packed {
    logic  pu_off;
    logic  mask;
    trig_e mode;
  } ctrl_t;
endpackage

// File: rtl/extint_rst_sync.sv
module extint_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/extint_pin_sync.sv
module extint_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_now,
  output logic pin_prev
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              hist_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign sync_d[i] = pin_n;
    end else begin : g_next
      assign sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      hist_q <= sync_q[STAGES-1];
    end
  end

  assign pin_now  = sync_q[STAGES-1];
  assign pin_prev = hist_q;
endmodule

// File: rtl/extint_trigger.sv
module extint_trigger
  import extint_pkg::*;
(
  input  trig_e mode,
  input  logic  pin_now,
  input  logic  pin_prev,
  output logic  evt
);
  logic fall;
  logic low;

  always_comb begin
    fall = pin_prev & ~pin_now;
    low  = ~pin_now;
    evt  = (mode == TRIG_LEVEL) ? low : fall;
  end
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt,
  output ctrl_t             ctrl_q,
  output logic              pend_q,
  output logic              reg_wr,
  output logic              ack_wr,
  output logic [DATA_W-1:0] rdata
);
  logic  sel;
  ctrl_t ctrl_d;
  logic  ctrl_en;
  logic  pend_d;
  logic  pend_en;
  logic  unused_wdata;

  assign unused_wdata = ^{wdata[7], wdata[5:3]};

  always_comb begin
    sel     = (addr == REG_ADDR);
    reg_wr  = we & sel;
    ack_wr  = reg_wr & wdata[B_ACK];
    ctrl_en = reg_wr;
    ctrl_d.pu_off = wdata[B_PUOFF];
    ctrl_d.mask   = wdata[B_MASK];
    ctrl_d.mode   = trig_e'(wdata[B_MODE]);
    pend_en = evt | ack_wr;
    pend_d  = evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{pu_off: 1'b0, mask: 1'b0, mode: TRIG_EDGE};
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[B_PUOFF] = ctrl_q.pu_off;
      rdata[B_PEND]  = pend_q;
      rdata[B_MASK]  = ctrl_q.mask;
      rdata[B_MODE]  = ctrl_q.mode;
    end
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 4'hC,
  parameter int                SYNC_STAGES = 2,
  parameter int                RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              pin_n,
  output logic              irq_req,
  output logic              pullup_off
);
  logic  rst_sync_n;
  logic  pin_now;
  logic  pin_prev;
  logic  trig_evt;
  ctrl_t ctrl_q;
  logic  pend_q;
  logic  mask_q;
  logic  reg_wr;
  logic  ack_wr;

  extint_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  extint_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_n    (pin_n),
    .pin_now  (pin_now),
    .pin_prev (pin_prev)
  );

  extint_trigger u_trig (
    .mode     (ctrl_q.mode),
    .pin_now  (pin_now),
    .pin_prev (pin_prev),
    .evt      (trig_evt)
  );

  extint_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .addr   (bus_addr),
    .we     (bus_we),
    .wdata  (bus_wdata),
    .evt    (trig_evt),
    .ctrl_q (ctrl_q),
    .pend_q (pend_q),
    .reg_wr (reg_wr),
    .ack_wr (ack_wr),
    .rdata  (bus_rdata)
  );

  assign mask_q     = ctrl_q.mask;
  assign irq_req    = pend_q & ~mask_q;
  assign pullup_off = ctrl_q.pu_off;
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic evt,
  input logic ack_wr,
  input logic pend,
  input logic mask,
  input logic irq_req,
  input logic wr,
  input logic wd_pu,
  input logic pullup_off
);
  p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !evt) |=> !pend);

  p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !ack_wr) |=> $stable(pend));

  p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq_req);

  p_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask && pend) |-> irq_req);

  p_pullup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (pullup_off == $past(wd_pu)));
endmodule

bind extint_ctrl extint_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .evt        (trig_evt),
  .ack_wr     (ack_wr),
  .pend       (pend_q),
  .mask       (mask_q),
  .irq_req    (irq_req),
  .wr         (reg_wr),
  .wd_pu      (bus_wdata[6]),
  .pullup_off (pullup_off)
);

// File: tb/extint_ctrl_test.sv
module extint_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] REG = 4'hC;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       pin_n;
  logic       irq_req;
  logic       pullup_off;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extint_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pin_n      (pin_n),
    .irq_req    (irq_req),
    .pullup_off (pullup_off)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    tick();
    bus_we    = 1'b0;
    bus_addr  = REG;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; pin_n = 1'b1; bus_we = 1'b0; bus_addr = REG; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ticks(4);
    chk("R1 reg", bus_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq_req}, 8'h00);
    chk("R1 pullup", {7'b0, pullup_off}, 8'h00);

    // R2 / R8 sweep of every write value with the pin idle
    for (int d = 0; d < 256; d++) begin
      wr(REG, 8'(d));
      chk("R2 readback", bus_rdata, 8'(d) & 8'h43);
      chk("R8 pullup", {7'b0, pullup_off}, {7'b0, 1'(d >> 6)});
      chk("R7 idle irq", {7'b0, irq_req}, 8'h00);
    end

    // R3 latency in edge mode
    wr(REG, 8'h00);
    pin_n = 1'b0;
    ticks(2);
    chk("R3 not yet", bus_rdata, 8'h00);
    tick();
    chk("R3 pending", bus_rdata, 8'h08);
    chk("R7 irq on", {7'b0, irq_req}, 8'h01);

    // R5 ack with pin held low in edge mode
    wr(REG, 8'h04);
    chk("R5 cleared", bus_rdata, 8'h00);
    chk("R5 irq off", {7'b0, irq_req}, 8'h00);
    ticks(3);
    chk("R5 no rearm", bus_rdata, 8'h00);

    // R10 rising edge ignored
    pin_n = 1'b1;
    ticks(4);
    chk("R10 rise", bus_rdata, 8'h00);

    // R7 latch sets while masked
    wr(REG, 8'h06);
    chk("R7 masked clear", bus_rdata, 8'h02);
    pin_n = 1'b0;
    ticks(3);
    chk("R7 masked pend", bus_rdata, 8'h0A);
    chk("R7 masked irq", {7'b0, irq_req}, 8'h00);
    wr(REG, 8'h00);
    chk("R7 unmask reg", bus_rdata, 8'h08);
    chk("R7 unmask irq", {7'b0, irq_req}, 8'h01);
    wr(REG, 8'h04);
    pin_n = 1'b1;
    ticks(3);
    chk("R5 clear again", bus_rdata, 8'h00);

    // R6 ack and event on the same edge
    pin_n = 1'b0;
    ticks(2);
    chk("R6 before", bus_rdata, 8'h00);
    wr(REG, 8'h04);
    chk("R6 collide", bus_rdata, 8'h08);
    chk("R6 irq", {7'b0, irq_req}, 8'h01);
    wr(REG, 8'h04);
    chk("R6 later ack", bus_rdata, 8'h00);
    pin_n = 1'b1;
    ticks(3);

    // R4 level mode
    wr(REG, 8'h01);
    chk("R4 idle", bus_rdata, 8'h01);
    pin_n = 1'b0;
    ticks(3);
    chk("R4 set", bus_rdata, 8'h09);
    wr(REG, 8'h05);
    chk("R4 rearm", bus_rdata, 8'h09);
    ticks(2);
    chk("R4 held", bus_rdata, 8'h09);
    pin_n = 1'b1;
    ticks(3);
    wr(REG, 8'h05);
    chk("R4 release", bus_rdata, 8'h01);
    ticks(3);
    chk("R4 stays", bus_rdata, 8'h01);

    // R9 other address
    wr(REG + 4'h1, 8'hFF);
    chk("R9 unchanged", bus_rdata, 8'h01);
    chk("R9 pullup", {7'b0, pullup_off}, 8'h00);
    bus_addr = REG + 4'h1;
    #1;
    chk("R9 read other", bus_rdata, 8'h00);
    bus_addr = REG;

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule